// File: doc/BRIEF.md
# Bank-Switched Memory Card Controller

This block holds the switch state of a 16 KB RAM expansion card. The card's RAM can stand in for the 12 KB ROM region at $D000-$FFFF of an 8-bit computer. The CPU changes the mapping by touching one of 16 switch addresses. The block sees each touch as a one-cycle strobe, together with a read/write flag and the low four address bits.

From these accesses the block keeps three pieces of state:
- where reads of the region come from (RAM or ROM);
- which of two 4 KB banks appears at $D000-$DFFF;
- a write-arming level that must reach its top step before the RAM accepts writes.

Its three registered outputs drive the card's memory decoder.

Write arming is the subtle part. Writes become possible only after two successive qualifying reads of the switches. A write access to the switches cannot advance the arming. A write access, or an even-address read, that leaves the arming half-done sends it back to zero.

Top module: `bank_sw_ctrl`

## Requirements
- R1: After reset, ram_rd_sel_o is 0 (reads come from ROM), ram_wr_en_o is 0 and bank_alt_o is 1 (second bank mapped).
- R2: On every switch access, read or write, bank_alt_o takes the inverse of address bit 3 at the clock edge that samples the strobe. Bit 3 = 0 maps the second bank.
- R3: On every switch access, read or write, ram_rd_sel_o becomes 1 when address bits [1:0] are 0 or 3, and 0 when they are 1 or 2.
- R4: Two successive read accesses with address bits [1:0] equal to 1 or 3 set ram_wr_en_o; a single such read does not.
- R5: Further qualifying reads once writes are enabled keep ram_wr_en_o at 1 (saturation).
- R6: Any access, read or write, with address bits [1:0] equal to 0 or 2 clears ram_wr_en_o and resets arming fully, from any level.
- R7: A write access with address bits [1:0] equal to 1 or 3 never advances arming, and leaves an already enabled state enabled.
- R8: A write access that would leave arming half-done returns it to zero, so one following qualifying read does not enable writes.
- R9: In cycles without a strobe, all three outputs hold their values.
- R10: ram_wr_en_o is 1 only in the fully armed state; CPU writes to the RAM region are dropped otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_strobe_i | input | 1 | One-cycle strobe for an access to the switch window |
| sw_write_i | input | 1 | 1 when the strobed access is a write |
| sw_addr_i | input | 4 | Low address bits of the switch access |
| ram_rd_sel_o | output | 1 | 1 selects card RAM as the source for reads of the region |
| ram_wr_en_o | output | 1 | 1 lets CPU writes reach card RAM |
| bank_alt_o | output | 1 | 1 maps the second 4 KB bank at $D000-$DFFF |

## Verification
The bound checker watches five things on every cycle:
- the bank output follows bit 3 of the previous strobe;
- the read source follows the action code;
- even actions always disarm;
- a write access never raises the write enable;
- outputs hold when there is no strobe.

It also checks that a rise of the write enable was caused by a read of an odd action.

The finer points of arming need the directed scenarios in the bench, because the arming level is not visible at the ports:
- two reads are needed, not one;
- a write cancels a half-done arm;
- an even read cancels it as well.

The bench exposes the hidden level by issuing one more qualifying read and watching whether writes become enabled. It also shows with a small RAM model that writes are dropped while disarmed.

// File: rtl/bank_sw_pkg.sv
package bank_sw_pkg;
  localparam int unsigned SW_ADDR_W = 4;

  // Decoded view of one switch access
  typedef struct packed {
    logic valid;
    logic is_write;
    logic advance;   // odd action: step arming
    logic ram_rd;    // read source after the access
    logic bank_alt;  // second bank after the access
  } sw_evt_t;
endpackage

// File: rtl/bank_sw_decode.sv
module bank_sw_decode
  import bank_sw_pkg::*;
#(
  parameter int unsigned BANK_BIT = 3
) (
  input  logic                 strobe_i,
  input  logic                 write_i,
  input  logic [SW_ADDR_W-1:0] addr_i,
  output sw_evt_t              evt_o
);
  logic [1:0] act;
  logic       unused_addr;

  assign act         = addr_i[1:0];
  assign unused_addr = addr_i[2];

  always_comb begin
    evt_o          = '0;
    evt_o.valid    = strobe_i;
    evt_o.is_write = write_i;
    evt_o.advance  = act[0];
    evt_o.ram_rd   = (act == 2'd0) || (act == 2'd3);
    evt_o.bank_alt = ~addr_i[BANK_BIT];
  end
endmodule

// File: rtl/bank_sw_arm.sv
module bank_sw_arm
  import bank_sw_pkg::*;
#(
  parameter int unsigned ARM_READS = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sw_evt_t evt_i,
  output logic    wr_en_o
);
  localparam int unsigned CNT_W = $clog2(ARM_READS + 1);
  localparam logic [CNT_W-1:0] ARM_MAX = CNT_W'(ARM_READS);

  logic [CNT_W-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (evt_i.valid) begin
      if (!evt_i.advance)
        lvl_d = '0;
      else if (!evt_i.is_write && lvl_q != ARM_MAX)
        lvl_d = lvl_q + CNT_W'(1);
      // a write never leaves arming part-way
      if (evt_i.is_write && lvl_d != ARM_MAX)
        lvl_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign wr_en_o = (lvl_q == ARM_MAX);
endmodule

// File: rtl/bank_sw_map.sv
module bank_sw_map
  import bank_sw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sw_evt_t evt_i,
  output logic    ram_rd_o,
  output logic    bank_alt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_rd_o   <= 1'b0;
      bank_alt_o <= 1'b1;
    end else if (evt_i.valid) begin
      ram_rd_o   <= evt_i.ram_rd;
      bank_alt_o <= evt_i.bank_alt;
    end
  end
endmodule

// File: rtl/bank_sw_ctrl.sv
module bank_sw_ctrl
  import bank_sw_pkg::*;
#(
  parameter int unsigned ARM_READS = 2,
  parameter int unsigned BANK_BIT  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_strobe_i,
  input  logic                 sw_write_i,
  input  logic [SW_ADDR_W-1:0] sw_addr_i,
  output logic                 ram_rd_sel_o,
  output logic                 ram_wr_en_o,
  output logic                 bank_alt_o
);
  sw_evt_t evt;

  bank_sw_decode #(.BANK_BIT(BANK_BIT)) u_dec (
    .strobe_i (sw_strobe_i),
    .write_i  (sw_write_i),
    .addr_i   (sw_addr_i),
    .evt_o    (evt)
  );

  bank_sw_arm #(.ARM_READS(ARM_READS)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .wr_en_o (ram_wr_en_o)
  );

  bank_sw_map u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .ram_rd_o   (ram_rd_sel_o),
    .bank_alt_o (bank_alt_o)
  );
endmodule

// File: rtl/bank_sw_ctrl_chk.sv
module bank_sw_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_strobe_i,
  input logic       sw_write_i,
  input logic [3:0] sw_addr_i,
  input logic       ram_rd_sel_o,
  input logic       ram_wr_en_o,
  input logic       bank_alt_o
);
  a_r2_bank_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_strobe_i |=> bank_alt_o == !$past(sw_addr_i[3]));

  a_r3_read_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_strobe_i |=> ram_rd_sel_o == ($past(sw_addr_i[1:0]) == 2'd0 || $past(sw_addr_i[1:0]) == 2'd3));

  a_r6_even_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_strobe_i && !sw_addr_i[0]) |=> !ram_wr_en_o);

  a_r7_write_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_strobe_i && sw_write_i && !ram_wr_en_o) |=> !ram_wr_en_o);

  a_r4_rise_from_odd_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_wr_en_o) |-> $past(sw_strobe_i && !sw_write_i && sw_addr_i[0]));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_strobe_i |=> ($stable(ram_rd_sel_o) && $stable(ram_wr_en_o) && $stable(bank_alt_o)));
endmodule

bind bank_sw_ctrl bank_sw_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_strobe_i  (sw_strobe_i),
  .sw_write_i   (sw_write_i),
  .sw_addr_i    (sw_addr_i),
  .ram_rd_sel_o (ram_rd_sel_o),
  .ram_wr_en_o  (ram_wr_en_o),
  .bank_alt_o   (bank_alt_o)
);

// File: tb/bank_sw_ctrl_test.sv
`timescale 1ns/1ps
module bank_sw_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sw_strobe_i = 1'b0;
  logic       sw_write_i = 1'b0;
  logic [3:0] sw_addr_i = '0;
  logic       ram_rd_sel_o, ram_wr_en_o, bank_alt_o;

  int checks = 0;
  int failures = 0;

  // RAM stand-in: CPU writes land only when enabled
  logic [7:0] ram_mdl [4];
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_a = '0;
  logic [7:0] cpu_d = '0;

  always #2.5 clk_i = ~clk_i;

  always_ff @(posedge clk_i)
    if (cpu_wr && ram_wr_en_o) ram_mdl[cpu_a] <= cpu_d;

  bank_sw_ctrl uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_strobe_i  (sw_strobe_i),
    .sw_write_i   (sw_write_i),
    .sw_addr_i    (sw_addr_i),
    .ram_rd_sel_o (ram_rd_sel_o),
    .ram_wr_en_o  (ram_wr_en_o),
    .bank_alt_o   (bank_alt_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // One strobed switch access; returns at the negedge after the sampling edge
  task automatic sw(input logic [3:0] a, input logic wr);
    @(negedge clk_i);
    sw_strobe_i = 1'b1;
    sw_write_i  = wr;
    sw_addr_i   = a;
    @(negedge clk_i);
    sw_strobe_i = 1'b0;
    sw_write_i  = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(ram_rd_sel_o, 1'b0, "R1 rom after reset");
    chk(ram_wr_en_o, 1'b0, "R1 wr disabled after reset");
    chk(bank_alt_o, 1'b1, "R1 second bank after reset");
  endtask

  task automatic t_bank();
    do_reset();
    sw(4'h8, 1'b0); chk(bank_alt_o, 1'b0, "R2 read bit3=1 -> first bank");
    sw(4'h2, 1'b0); chk(bank_alt_o, 1'b1, "R2 read bit3=0 -> second bank");
    sw(4'hB, 1'b1); chk(bank_alt_o, 1'b0, "R2 write bit3=1 -> first bank");
    sw(4'h4, 1'b1); chk(bank_alt_o, 1'b1, "R2 write bit3=0 -> second bank");
  endtask

  task automatic t_read_src();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      logic [3:0] a;
      logic       wr;
      a  = 4'(i % 4) | ((i % 3 == 0) ? 4'h8 : 4'h0);
      wr = (i >= 4);
      sw(a, wr);
      chk(ram_rd_sel_o, (a[1:0] == 2'd0) || (a[1:0] == 2'd3), "R3 read source per action");
    end
  endtask

  task automatic t_arm();
    do_reset();
    sw(4'h1, 1'b0); chk(ram_wr_en_o, 1'b0, "R4 one odd read not enough");
    sw(4'h3, 1'b0); chk(ram_wr_en_o, 1'b1, "R4 two odd reads enable");
    sw(4'hB, 1'b0); chk(ram_wr_en_o, 1'b1, "R5 third read stays enabled");
    sw(4'h9, 1'b0); chk(ram_wr_en_o, 1'b1, "R5 saturated");
  endtask

  task automatic t_disable();
    do_reset();
    sw(4'h1, 1'b0); sw(4'h1, 1'b0);
    sw(4'hA, 1'b0); chk(ram_wr_en_o, 1'b0, "R6 read action 2 disarms");
    sw(4'h3, 1'b0); chk(ram_wr_en_o, 1'b0, "R6 disarm was full");
    sw(4'h3, 1'b0);
    sw(4'h8, 1'b1); chk(ram_wr_en_o, 1'b0, "R6 write action 0 disarms");
    sw(4'h1, 1'b0); sw(4'h0, 1'b0); sw(4'h3, 1'b0);
    chk(ram_wr_en_o, 1'b0, "R6 even read cancels half arm");
  endtask

  task automatic t_write_no_arm();
    do_reset();
    sw(4'h1, 1'b1); sw(4'h3, 1'b1); sw(4'h9, 1'b1);
    chk(ram_wr_en_o, 1'b0, "R7 writes do not arm");
    sw(4'h1, 1'b0); chk(ram_wr_en_o, 1'b0, "R7 writes added no level");
    sw(4'h1, 1'b0);
    sw(4'h3, 1'b1); chk(ram_wr_en_o, 1'b1, "R7 write keeps enabled");
  endtask

  task automatic t_half_cancel();
    do_reset();
    sw(4'h1, 1'b0);
    sw(4'h3, 1'b1); chk(ram_wr_en_o, 1'b0, "R8 write during half arm");
    sw(4'h1, 1'b0); chk(ram_wr_en_o, 1'b0, "R8 half arm was cancelled");
    sw(4'h1, 1'b0); chk(ram_wr_en_o, 1'b1, "R8 re-arm needs two reads");
  endtask

  task automatic t_hold();
    do_reset();
    sw(4'h3, 1'b0); sw(4'h3, 1'b0);
    repeat (5) @(negedge clk_i);
    chk(ram_wr_en_o, 1'b1, "R9 wr enable held");
    chk(ram_rd_sel_o, 1'b1, "R9 read source held");
    chk(bank_alt_o, 1'b1, "R9 bank held");
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_wr = 1'b1; cpu_a = a; cpu_d = d;
    @(negedge clk_i);
    cpu_wr = 1'b0;
  endtask

  task automatic t_ram_gate();
    do_reset();
    for (int i = 0; i < 4; i++) ram_mdl[i] = 8'h00;
    cpu_write(2'd1, 8'h5A);
    chk(ram_mdl[1] == 8'h5A, 1'b0, "R10 write dropped while disabled");
    sw(4'h1, 1'b0);
    cpu_write(2'd1, 8'h66);
    chk(ram_mdl[1] == 8'h66, 1'b0, "R10 write dropped while half armed");
    sw(4'h1, 1'b0);
    cpu_write(2'd1, 8'hA5);
    chk(ram_mdl[1] == 8'hA5, 1'b1, "R10 write lands when enabled");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_bank();
        t_read_src();
        t_arm();
        t_disable();
        t_write_no_arm();
        t_half_cancel();
        t_hold();
        t_ram_gate();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule